// File: doc/BRIEF.md
# Triple-Redundancy Fault Manager

This block watches three processor replicas that run in lockstep. In every cycle it compares their output buses in pairs. It also takes in mismatch flags that the replicas' own comparison logic reports. The first pattern of disagreement is held in a status word that software can read. From that pattern the block decides among three outcomes: all replicas agree, exactly one replica is at fault and can be recovered, or more than one replica is at fault and the subsystem is lost. While the subsystem can still be trusted, the block drives a bitwise two-of-three majority of the replica buses onto the shared bus.

When a single replica is found faulty, the block raises a break request. The processors can then save their state and ask for a subsystem reset. That reset puts the block back into voting. It keeps the captured fault and sets a flag that tells the restarted software that this start is a recovery and not a power-on start. Software clears the status word with a single strobe once it has handled the recovery. A fatal fault raises an output for logic outside the subsystem, and only a cold reset clears it.

Top module: `tmr_fault_mgr`

## Requirements
- R1: While not fatal, `voted_bus` equals the bitwise majority of the three replica buses in the same cycle. In the fatal mode `voted_bus` is all zeros.
- R2: The pair flags are bit 0 (replica 1 vs 2), bit 1 (replica 1 vs 3) and bit 2 (replica 2 vs 3). Each pair flag is set by a bus inequality or by the matching bit of `pair_flag_in`. With no fault held, a nonzero pattern is captured into `status[2:0]` one cycle later, and `aux_fault_in` is captured into `status[20:16]` on the same edge.
- R3: A captured pattern of 3'b011, 3'b101 or 3'b110 with `status[20:16]` zero raises `brk_req` in the cycle after the capture. In that case `faulty_id` reads 1, 2 or 3 respectively. `faulty_id` reads 0 for any other status.
- R4: Any other captured nonzero fault (patterns 001, 010, 100 or 111, or any nonzero auxiliary bit) raises `fatal` instead of `brk_req`. `brk_req` and `fatal` are never high together.
- R5: While a fault is held, mismatches that set only already-captured bits leave the status and the mode unchanged.
- R6: While a fault is held, a mismatch that sets a pair or auxiliary bit not yet captured moves the block to fatal one cycle later, and leaves the status unchanged.
- R7: `sub_rst` while `brk_req` is high drops `brk_req` on the next edge and returns the block to voting. It keeps the fault bits and sets `status[3]` (recovery flag).
- R8: `sts_clr` clears the whole status word on the next edge and ignores mismatches in that cycle. If `sub_rst` arrives together with `sts_clr` while `brk_req` is high, only `status[3]` is left set.
- R9: Once `fatal` is high it stays high through `sub_rst` and `sts_clr` until a cold reset.
- R10: A cold reset (`rst`, synchronous, active high) clears the status, `brk_req`, `fatal` and `faulty_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Cold reset, synchronous, active high |
| sub_rst | input | 1 | Subsystem reset requested by software |
| rep1_bus | input | DATA_W | Output bus of replica 1 |
| rep2_bus | input | DATA_W | Output bus of replica 2 |
| rep3_bus | input | DATA_W | Output bus of replica 3 |
| pair_flag_in | input | 3 | Externally reported pair mismatches, same bit order as status[2:0] |
| aux_fault_in | input | 5 | Other fault sources, captured into status[20:16] |
| sts_clr | input | 1 | Status clear strobe |
| voted_bus | output | DATA_W | Majority-voted bus |
| status | output | 32 | Status word: pair flags [2:0], recovery flag [3], auxiliary [20:16] |
| brk_req | output | 1 | Break request for a recoverable fault |
| fatal | output | 1 | Unrecoverable fault indication |
| faulty_id | output | 2 | Faulty replica number (1..3), 0 when none is identified |

## Verification
The bench targets the single-pair patterns, which a buggy design would classify as recoverable and then send a break instead of going fatal. It also targets a recoverable pattern that carries an auxiliary bit, which a design that ignores bits 20..16 would let through. It drives continued mismatches from an already-named replica, which a design without the new-bit test would wrongly escalate. It drives a fresh pair in the same situation, which a design that checks only "any mismatch" could not tell apart from the first case. Other cases check that the recovery flag survives a subsystem reset while a cold reset clears it, that `fatal` does not fall on `sub_rst` or `sts_clr`, and that a clear and a subsystem reset in the same cycle leave only the recovery flag set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int STS_W     = 32;
    localparam int PAIR_W    = 3;
    localparam int AUX_W     = 5;
    localparam int AUX_LSB   = 16;
    localparam int RECOV_BIT = 3;
    localparam int ID_W      = 2;

    typedef enum logic [1:0] {
        MODE_VOTE  = 2'd0,
        MODE_BRK   = 2'd1,
        MODE_FATAL = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_SINGLE = 2'd1,
        CLS_MULTI  = 2'd2
    } cls_e;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic              recov;
        logic [PAIR_W-1:0] pair;
    } fault_rec_t;

    // Two agreeing pair flags name the replica both pairs share.
    function automatic logic [ID_W-1:0] culprit(input logic [PAIR_W-1:0] p);
        case (p)
            3'b011:  return 2'd1;
            3'b101:  return 2'd2;
            3'b110:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic cls_e classify(input logic [PAIR_W-1:0] p,
                                      input logic [AUX_W-1:0]  a);
        if (p == '0 && a == '0)
            return CLS_NONE;
        if (a == '0 && culprit(p) != 2'd0)
            return CLS_SINGLE;
        return CLS_MULTI;
    endfunction

    function automatic logic [STS_W-1:0] to_status(input fault_rec_t r);
        logic [STS_W-1:0] s;
        s = '0;
        s[PAIR_W-1:0]        = r.pair;
        s[RECOV_BIT]         = r.recov;
        s[AUX_LSB +: AUX_W]  = r.aux;
        return s;
    endfunction

endpackage

// File: rtl/tmr_pair_cmp.sv
module tmr_pair_cmp
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    input  logic [DATA_W-1:0] bus_c,
    input  logic [PAIR_W-1:0] ext_flag,
    output logic [PAIR_W-1:0] pair_flag
);
    logic [PAIR_W-1:0] bus_diff;

    assign bus_diff[0] = (bus_a != bus_b);
    assign bus_diff[1] = (bus_a != bus_c);
    assign bus_diff[2] = (bus_b != bus_c);

    assign pair_flag = bus_diff | ext_flag;
endmodule

// File: rtl/tmr_majority.sv
module tmr_majority #(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    input  logic [DATA_W-1:0] bus_c,
    output logic [DATA_W-1:0] voted
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign voted[i] = en & ((bus_a[i] & bus_b[i]) |
                                (bus_a[i] & bus_c[i]) |
                                (bus_b[i] & bus_c[i]));
    end
endmodule

// File: rtl/tmr_fault_ctrl.sv
module tmr_fault_ctrl
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_rst,
    input  logic              sts_clr,
    input  logic [PAIR_W-1:0] pair_now,
    input  logic [AUX_W-1:0]  aux_now,
    output fault_rec_t        rec_q,
    output mode_e             mode_q
);
    fault_rec_t rec_d;
    mode_e      mode_d;
    cls_e       cls_now;
    logic       pending;
    logic       fresh;
    logic       seen_now;
    logic       capture;
    logic       escalate;

    assign pending  = (|rec_q.pair) | (|rec_q.aux);
    assign fresh    = (|(pair_now & ~rec_q.pair)) | (|(aux_now & ~rec_q.aux));
    assign seen_now = (|pair_now) | (|aux_now);
    assign cls_now  = classify(pair_now, aux_now);
    assign capture  = !pending && !sts_clr && seen_now;
    assign escalate = pending && !sts_clr && fresh;

    always_comb begin
        rec_d = rec_q;
        if (sts_clr) begin
            rec_d = '0;
        end else if (capture) begin
            rec_d.pair = pair_now;
            rec_d.aux  = aux_now;
        end
        if (sub_rst && mode_q == MODE_BRK)
            rec_d.recov = 1'b1;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FATAL: mode_d = MODE_FATAL;
            MODE_BRK: begin
                if (sub_rst)
                    mode_d = MODE_VOTE;
                else if (escalate)
                    mode_d = MODE_FATAL;
                else if (capture)
                    mode_d = (cls_now == CLS_SINGLE) ? MODE_BRK : MODE_FATAL;
            end
            default: begin
                if (escalate)
                    mode_d = MODE_FATAL;
                else if (capture)
                    mode_d = (cls_now == CLS_SINGLE) ? MODE_BRK : MODE_FATAL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q  <= '0;
            mode_q <= MODE_VOTE;
        end else begin
            rec_q  <= rec_d;
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/tmr_fault_mgr.sv
module tmr_fault_mgr
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_rst,
    input  logic [DATA_W-1:0] rep1_bus,
    input  logic [DATA_W-1:0] rep2_bus,
    input  logic [DATA_W-1:0] rep3_bus,
    input  logic [2:0]        pair_flag_in,
    input  logic [4:0]        aux_fault_in,
    input  logic              sts_clr,
    output logic [DATA_W-1:0] voted_bus,
    output logic [31:0]       status,
    output logic              brk_req,
    output logic              fatal,
    output logic [1:0]        faulty_id
);
    logic [PAIR_W-1:0] pair_now;
    fault_rec_t        rec_q;
    mode_e             mode_q;

    tmr_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
        .bus_a     (rep1_bus),
        .bus_b     (rep2_bus),
        .bus_c     (rep3_bus),
        .ext_flag  (pair_flag_in),
        .pair_flag (pair_now)
    );

    tmr_fault_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sub_rst  (sub_rst),
        .sts_clr  (sts_clr),
        .pair_now (pair_now),
        .aux_now  (aux_fault_in),
        .rec_q    (rec_q),
        .mode_q   (mode_q)
    );

    tmr_majority #(.DATA_W(DATA_W)) u_vote (
        .en    (mode_q != MODE_FATAL),
        .bus_a (rep1_bus),
        .bus_b (rep2_bus),
        .bus_c (rep3_bus),
        .voted (voted_bus)
    );

    assign status    = to_status(rec_q);
    assign brk_req   = (mode_q == MODE_BRK);
    assign fatal     = (mode_q == MODE_FATAL);
    assign faulty_id = (rec_q.aux == '0) ? culprit(rec_q.pair) : 2'd0;
endmodule

// File: rtl/tmr_fault_mgr_chk.sv
module tmr_fault_mgr_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sub_rst,
    input logic              sts_clr,
    input logic [DATA_W-1:0] voted_bus,
    input logic [31:0]       status,
    input logic              brk_req,
    input logic              fatal
);
    a_r1_fatal_quiet: assert property (@(posedge clk) disable iff (rst)
        fatal |-> voted_bus == '0);

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(brk_req && fatal));

    a_r5_first_kept: assert property (@(posedge clk) disable iff (rst)
        (status[2:0] != 3'b000 && !sts_clr) |=> status[2:0] == $past(status[2:0]));

    a_r7_subrst_recovers: assert property (@(posedge clk) disable iff (rst)
        (brk_req && sub_rst) |=> (!brk_req && status[3]));

    a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !(sub_rst && brk_req)) |=> status == 32'd0);

    a_r9_fatal_holds: assert property (@(posedge clk) disable iff (rst)
        fatal |=> fatal);
endmodule

bind tmr_fault_mgr tmr_fault_mgr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sub_rst   (sub_rst),
    .sts_clr   (sts_clr),
    .voted_bus (voted_bus),
    .status    (status),
    .brk_req   (brk_req),
    .fatal     (fatal)
);

// File: tb/tb_tmr_fault_mgr.sv
module tb_tmr_fault_mgr;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         sub_rst;
    logic [W-1:0] r1, r2, r3;
    logic [2:0]   pflag;
    logic [4:0]   aux;
    logic         clr;
    logic [W-1:0] voted_bus;
    logic [31:0]  status;
    logic         brk_req;
    logic         fatal;
    logic [1:0]   faulty_id;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    logic [2:0] m_pair;
    logic [4:0] m_aux;
    logic       m_recov;
    int         m_mode; // 0 vote, 1 break, 2 fatal

    always #10 clk = ~clk;

    tmr_fault_mgr #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .sub_rst(sub_rst),
        .rep1_bus(r1), .rep2_bus(r2), .rep3_bus(r3),
        .pair_flag_in(pflag), .aux_fault_in(aux), .sts_clr(clr),
        .voted_bus(voted_bus), .status(status), .brk_req(brk_req),
        .fatal(fatal), .faulty_id(faulty_id)
    );

    function automatic logic [W-1:0] maj(input logic [W-1:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [1:0] who(input logic [2:0] p);
        if (p == 3'b011) return 2'd1;
        if (p == 3'b101) return 2'd2;
        if (p == 3'b110) return 2'd3;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] es;
        es = '0;
        es[2:0]   = m_pair;
        es[3]     = m_recov;
        es[20:16] = m_aux;
        chk({tag, " status"},    64'(status),    64'(es));
        chk({tag, " brk_req"},   64'(brk_req),   64'(m_mode == 1));
        chk({tag, " fatal"},     64'(fatal),     64'(m_mode == 2));
        chk({tag, " faulty_id"}, 64'(faulty_id), 64'((m_aux == 0) ? who(m_pair) : 2'd0));
    endtask

    task automatic step(input string tag, input logic [W-1:0] a, b, c,
                        input logic [2:0] ef, input logic [4:0] ax,
                        input bit sr, input bit cl);
        logic [2:0] pn;
        bit pend, fresh, seen, single, cap, esc;
        int old;
        @(negedge clk);
        r1 = a; r2 = b; r3 = c; pflag = ef; aux = ax; sub_rst = sr; clr = cl;
        #2;
        chk({tag, " R1 vote"}, 64'(voted_bus), 64'((m_mode == 2) ? '0 : maj(a, b, c)));
        @(posedge clk);
        pn     = {b != c, a != c, a != b} | ef;
        pend   = (m_pair != 0) || (m_aux != 0);
        fresh  = ((pn & ~m_pair) != 0) || ((ax & ~m_aux) != 0);
        seen   = (pn != 0) || (ax != 0);
        single = (ax == 0) && (who(pn) != 0);
        cap    = !pend && !cl && seen;
        esc    = pend && !cl && fresh;
        old    = m_mode;
        if (old == 1 && sr)  m_mode = 0;
        else if (old == 2)   m_mode = 2;
        else if (esc)        m_mode = 2;
        else if (cap)        m_mode = single ? 1 : 2;
        if (cl) begin
            m_pair = 0; m_aux = 0; m_recov = 0;
        end else if (cap) begin
            m_pair = pn; m_aux = ax;
        end
        if (sr && old == 1) m_recov = 1;
        #2;
        check_regs(tag);
    endtask

    task automatic cold_reset();
        @(negedge clk);
        rst = 1; sub_rst = 0; clr = 0; pflag = 0; aux = 0;
        r1 = 0; r2 = 0; r3 = 0;
        @(posedge clk);
        m_pair = 0; m_aux = 0; m_recov = 0; m_mode = 0;
        #2;
        check_regs("R10 reset");
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #3000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] A;
        void'($urandom(32'd4242));
        A = 32'h1234_5678;
        cold_reset();

        step("R1 agree",           A, A, A, 0, 0, 0, 0);
        step("R2 R3 replica1",     A ^ 1, A, A, 0, 0, 0, 0);
        step("R5 same culprit",    A ^ 16, A, A, 0, 0, 0, 0);
        step("R7 subsystem reset", A, A, A, 0, 0, 1, 0);
        step("R5 after recovery",  A ^ 2, A, A, 0, 0, 0, 0);
        step("R8 clear",           A, A, A, 0, 0, 0, 1);
        step("R3 replica2",        A, A ^ 2, A, 0, 0, 0, 0);
        step("R7 reset again",     A, A, A, 0, 0, 1, 0);
        step("R8 clear again",     A, A, A, 0, 0, 0, 1);
        step("R3 replica3",        A, A, A ^ 4, 0, 0, 0, 0);
        step("R6 escalate",        A, A ^ 8, A ^ 4, 0, 0, 0, 0);
        step("R9 subrst in fatal", A, A, A, 0, 0, 1, 0);
        step("R9 clear in fatal",  A, A, A, 0, 0, 0, 1);
        step("R1 fatal quiet",     A, A, A, 0, 0, 0, 0);
        cold_reset();
        step("R4 pattern 001",     A, A, A, 3'b001, 0, 0, 0);
        cold_reset();
        step("R4 pattern 010",     A, A, A, 3'b010, 0, 0, 0);
        cold_reset();
        step("R4 pattern 100",     A, A, A, 3'b100, 0, 0, 0);
        cold_reset();
        step("R4 aux only",        A, A, A, 0, 5'b00100, 0, 0);
        cold_reset();
        step("R4 single plus aux", A ^ 1, A, A, 0, 5'b00001, 0, 0);
        cold_reset();
        step("R4 three way",       A ^ 1, A ^ 2, A ^ 4, 0, 0, 0, 0);
        cold_reset();
        step("R3 via ext flags",   A, A, A, 3'b110, 0, 0, 0);
        step("R8 clear with reset", A, A, A, 0, 0, 1, 1);
        step("R10 pre cold",       A, A, A, 0, 0, 0, 0);
        cold_reset();

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] base, a, b, c, mask;
            logic [2:0] ef;
            logic [4:0] ax;
            int r;
            bit sr, cl;
            base = $urandom; a = base; b = base; c = base;
            mask = $urandom; if (mask == 0) mask = 1;
            ef = 0; ax = 0;
            r = $urandom % 100;
            if (r < 6) begin
                case ($urandom % 3)
                    0: a = a ^ mask;
                    1: b = b ^ mask;
                    default: c = c ^ mask;
                endcase
            end else if (r < 8) begin
                a = a ^ mask; c = c ^ (mask << 1);
            end else if (r == 8) begin
                ef = 3'(1 << ($urandom % 3));
            end else if (r == 9) begin
                ax = 5'(1 << ($urandom % 5));
            end
            sr = (m_mode == 1 && ($urandom % 4 == 0)) || ($urandom % 40 == 0);
            cl = ($urandom % 25 == 0);
            step("R5 R6 random", a, b, c, ef, ax, sr, cl);
            if (m_mode == 2 && ($urandom % 8 == 0))
                cold_reset();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule